// File: doc/BRIEF.md
# Block Alignment Lock Machine

This block receives a line stream one 66-bit word per valid cycle. The words are not aligned to the code blocks carried inside the stream. Each code block is a 2-bit sync header followed by a 64-bit payload. The block keeps the previous word, joins it to the current word, and takes from the joined pair a 66-bit candidate at its current bit offset. A header is valid only when its two bits differ.

While searching, the block counts valid headers in a row at one offset. Any invalid header sends it to the next offset. After 64 valid headers in a row it declares lock. From then on it delivers each aligned header and payload with a one-cycle strobe. It also keeps checking headers over fixed windows of 64 blocks. A false lock, or a real lock that later breaks, is therefore dropped, and the search continues at the next offset.

Top module: `block_lock`

## Requirements
- R1: A header is valid only when its two bits differ (01 or 10). 00 and 11 are invalid. Header bit 0 is the earlier-received bit and appears on `hdr[0]`.
- R2: Bit 0 of `in_word` is the earliest received bit. The candidate block is the 66 consecutive bits that start at `offset` within {current word, previous word}, with the previous word in the low bits. The first valid word after reset only fills the previous-word store and is not evaluated.
- R3: While searching, `locked` rises on the clock edge that evaluates the 64th consecutive valid header at one offset, and not earlier.
- R4: While searching, an invalid header clears the run count and advances `offset` by one. Offset 65 wraps to 0, so all 66 offsets are reachable. `offset` changes only on an invalid header.
- R5: The run must be unbroken. A single invalid header among the first 64 blocks prevents lock at the 64th block.
- R6: While locked, blocks are grouped into windows of 64 that start at lock. The 16th invalid header within one window clears `locked` and advances `offset` by one.
- R7: A window with at most 15 invalid headers keeps lock, and the invalid count restarts at each window boundary. Two windows with 10 invalid headers each do not drop lock.
- R8: When the 16th invalid header falls on the last block of a window, lock is still dropped. The drop takes priority over the window restart.
- R9: `blk_valid` pulses for one cycle after each block that is evaluated while `locked` was already set. That includes the block that causes a drop, and excludes the block that completes lock. `hdr` and `payload` carry that block; `payload[0]` is the first payload bit.
- R10: Synchronous active-high `rst` clears `locked`, `blk_valid` and all counters, and sets `offset` to 0.
- R11: For a stream whose blocks start at any bit position 0 to 65 of a word, the block locks with `offset` equal to that position and delivers correct payloads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A new received word is present |
| in_word | input | 66 | Received bits, bit 0 earliest |
| locked | output | 1 | Block alignment acquired |
| offset | output | 7 | Current candidate bit offset, 0 to 65 |
| hdr | output | 2 | Header of the delivered block |
| payload | output | 64 | Payload of the delivered block |
| blk_valid | output | 1 | One-cycle strobe for `hdr` and `payload` |

## Verification
Two events can fall in the same cycle: the window boundary, which restarts the invalid-header count, and the 16th invalid header, which drops lock. The stimulus forces this by corrupting exactly the last 16 blocks of the first locked window. The expected result at that edge is that lock clears, the offset moves by one, and the strobe still delivers the corrupted header. Separate windows of 15 bad headers, and two windows of 10 each, show that neither the window restart nor the drop fires when it should not.

// File: rtl/block_lock.sv
module block_lock #(
  parameter int PAY_W     = 64,
  parameter int LOCK_RUN  = 64,
  parameter int WIN_LEN   = 64,
  parameter int BAD_LIMIT = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          in_valid,
  input  logic [PAY_W+1:0]              in_word,
  output logic                          locked,
  output logic [$clog2(PAY_W+2)-1:0]    offset,
  output logic [1:0]                    hdr,
  output logic [PAY_W-1:0]              payload,
  output logic                          blk_valid
);
  localparam int BLK_W = PAY_W + 2;
  localparam int OFF_W = $clog2(BLK_W);
  localparam int RUN_W = $clog2(LOCK_RUN);
  localparam int WIN_W = $clog2(WIN_LEN);
  localparam int BAD_W = $clog2(BAD_LIMIT);
  localparam logic [OFF_W-1:0] OFF_LAST = OFF_W'(BLK_W - 1);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(LOCK_RUN - 1);
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_LEN - 1);
  localparam logic [BAD_W-1:0] BAD_LAST = BAD_W'(BAD_LIMIT - 1);

  logic [BLK_W-1:0]   prev_q;
  logic               primed_q;
  logic [RUN_W-1:0]   run_q;
  logic [WIN_W-1:0]   win_q;
  logic [BAD_W-1:0]   bad_q;

  wire [2*BLK_W-1:0] joined  = {in_word, prev_q};
  wire [BLK_W-1:0]   cand    = joined[offset +: BLK_W];
  wire               hdr_ok  = cand[0] ^ cand[1];
  wire               eval    = in_valid && primed_q;
  wire [OFF_W-1:0]   off_nxt = (offset == OFF_LAST) ? '0 : offset + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q    <= '0;
      primed_q  <= 1'b0;
      run_q     <= '0;
      win_q     <= '0;
      bad_q     <= '0;
      locked    <= 1'b0;
      offset    <= '0;
      hdr       <= '0;
      payload   <= '0;
      blk_valid <= 1'b0;
    end else begin
      blk_valid <= 1'b0;
      if (in_valid) begin
        prev_q   <= in_word;
        primed_q <= 1'b1;
      end
      if (eval) begin
        if (locked) begin
          blk_valid <= 1'b1;
          hdr       <= cand[1:0];
          payload   <= cand[BLK_W-1:2];
          if (!hdr_ok && bad_q == BAD_LAST) begin
            locked <= 1'b0;
            offset <= off_nxt;
            bad_q  <= '0;
            win_q  <= '0;
            run_q  <= '0;
          end else if (win_q == WIN_LAST) begin
            win_q <= '0;
            bad_q <= '0;
          end else begin
            win_q <= win_q + 1'b1;
            if (!hdr_ok) bad_q <= bad_q + 1'b1;
          end
        end else if (!hdr_ok) begin
          run_q  <= '0;
          offset <= off_nxt;
        end else if (run_q == RUN_LAST) begin
          locked <= 1'b1;
          run_q  <= '0;
          win_q  <= '0;
          bad_q  <= '0;
        end else begin
          run_q <= run_q + 1'b1;
        end
      end
    end
  end

  AST_OFF_RANGE: assert property (@(posedge clk) disable iff (rst)
    offset <= OFF_LAST); // R4

  AST_SLIP_CAUSE: assert property (@(posedge clk) disable iff (rst)
    !$stable(offset) |-> $past(eval && !hdr_ok)); // R4

  AST_LOCK_RUN: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(run_q == RUN_LAST && hdr_ok && eval)); // R3

  AST_VALID_LOCKED: assert property (@(posedge clk) disable iff (rst)
    blk_valid |-> $past(locked && eval)); // R9

  AST_DROP_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $fell(locked) |-> $past(bad_q == BAD_LAST && !hdr_ok)); // R6
endmodule

// File: tb/tb_block_lock.sv
module tb_block_lock;
  localparam int CLK_PERIOD = 10;
  localparam int NOFF = 5;
  localparam int OFFS [NOFF] = '{0, 1, 37, 65, 20};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [65:0] in_word = '0;
  logic        locked;
  logic [6:0]  offset;
  logic [1:0]  hdr;
  logic [63:0] payload;
  logic        blk_valid;

  int  checks = 0;
  int  errors = 0;
  int  cycles = 0;
  bit  done = 0;
  int  shift_s = 0;
  bit  zero_mode = 0;
  bit  bad_blk [0:1023];

  block_lock dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
    .locked(locked), .offset(offset), .hdr(hdr), .payload(payload),
    .blk_valid(blk_valid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit pat(input int j, input int r);
    int unsigned x;
    x = (j * 32'h9E3779B1) ^ (r * 32'h85EBCA6B);
    x = x ^ (x >> 15);
    x = x * 32'h2C1B3C6D;
    x = x ^ (x >> 12);
    return x[9];
  endfunction

  function automatic bit sbit(input int p);
    int q, j, r;
    if (zero_mode) return 1'b0;
    if (p < shift_s) return pat(5000, p);
    q = p - shift_s; j = q / 66; r = q % 66;
    if (r < 2) begin
      if (j < 1024 && bad_blk[j]) return 1'b1;
      return (r == 0);
    end
    return pat(j, r);
  endfunction

  function automatic logic [63:0] exp_pay(input int j);
    logic [63:0] v;
    for (int r = 2; r < 66; r++) v[r-2] = pat(j, r);
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push(input int w);
    for (int i = 0; i < 66; i++) in_word[i] = sbit(66*w + i);
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic do_reset(input int s);
    for (int k = 0; k < 1024; k++) bad_blk[k] = 1'b0;
    zero_mode = 0;
    shift_s = s;
    rst = 1'b1; in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below 150000", cycles);
      finish_run();
    end
  end

  initial begin
    @(negedge clk);
    // R11 table walk: each entry a block start position and the expected offset
    for (int t = 0; t < NOFF; t++) begin
      int w;
      do_reset(OFFS[t]);
      w = 0;
      while (!locked && w < 800) begin push(w); w++; end
      check(locked == 1'b1, "R11 lock reached", locked, 1);
      check(offset == 7'(OFFS[t]), "R11 offset", offset, OFFS[t]);
      push(w);
      check(blk_valid && hdr == 2'b01 && payload == exp_pay(w-1), "R11 R9 payload",
            payload, exp_pay(w-1));
    end

    // R10 reset state
    do_reset(0);
    check(!locked && offset == 0 && !blk_valid, "R10 reset", {locked, offset, blk_valid}, 0);

    // R3 exact lock edge, R9 first strobe, R1 R2 header placement
    for (int w = 0; w < 64; w++) push(w);
    check(locked == 1'b0, "R3 not yet locked after 63 blocks", locked, 0);
    push(64);
    check(locked == 1'b1 && offset == 0, "R3 lock on 64th block", {locked, offset}, {1'b1, 7'd0});
    check(blk_valid == 1'b0, "R9 no strobe for lock-completing block", blk_valid, 0);
    push(65);
    check(blk_valid == 1'b1 && hdr == 2'b01, "R1 R9 header on strobe", {blk_valid, hdr}, 3'b101);
    check(payload == exp_pay(64), "R2 R9 payload bits", payload, exp_pay(64));

    // R4 slip per invalid header and wrap
    do_reset(0);
    zero_mode = 1;
    for (int w = 0; w < 5; w++) push(w);
    check(offset == 4 && !locked, "R4 slip by one per bad header", offset, 4);
    for (int w = 5; w < 67; w++) push(w);
    check(offset == 0, "R4 wrap 65 to 0", offset, 0);

    // R5 broken run blocks lock
    do_reset(0);
    bad_blk[40] = 1'b1;
    for (int w = 0; w < 65; w++) push(w);
    check(locked == 1'b0, "R5 run broken", locked, 0);

    // R7 fifteen bad headers keep lock
    do_reset(0);
    for (int k = 64; k < 79; k++) bad_blk[k] = 1'b1;
    for (int w = 0; w < 140; w++) push(w);
    check(locked == 1'b1 && offset == 0, "R7 15 bad keep lock", {locked, offset}, {1'b1, 7'd0});

    // R6 sixteen bad drop lock
    do_reset(0);
    for (int k = 64; k < 80; k++) bad_blk[k] = 1'b1;
    for (int w = 0; w < 80; w++) push(w);
    check(locked == 1'b1, "R6 still locked after 15 bad", locked, 1);
    push(80);
    check(locked == 1'b0 && offset == 1, "R6 drop on 16th bad", {locked, offset}, {1'b0, 7'd1});
    check(blk_valid == 1'b1 && hdr == 2'b11, "R9 strobe on dropping block", {blk_valid, hdr}, 3'b111);

    // R7 count restarts per window
    do_reset(0);
    for (int k = 64; k < 74; k++) bad_blk[k] = 1'b1;
    for (int k = 128; k < 138; k++) bad_blk[k] = 1'b1;
    for (int w = 0; w < 150; w++) push(w);
    check(locked == 1'b1, "R7 window restart", locked, 1);

    // R8 16th bad on the last block of a window
    do_reset(0);
    for (int k = 112; k < 128; k++) bad_blk[k] = 1'b1;
    for (int w = 0; w < 128; w++) push(w);
    check(locked == 1'b1, "R8 locked before window end", locked, 1);
    push(128);
    check(locked == 1'b0 && offset == 1, "R8 drop wins at window end", {locked, offset}, {1'b0, 7'd1});
    check(blk_valid == 1'b1 && hdr == 2'b11, "R8 strobe at window end", {blk_valid, hdr}, 3'b111);

    finish_run();
  end
endmodule